// File: doc/BRIEF.md
# Streaming Neighbor Aggregator

This block folds the incoming messages of one destination node into a fixed-size running record per feature lane and, once told the neighbor list is over, emits one reduced vector. Messages arrive one vector per transfer, each lane a signed fixed-point value. The reduction kind is chosen per transfer by a mode input: sum, minimum, maximum, mean or population variance. Nothing is kept about individual neighbors. Each lane holds only a running sum, a running minimum, a running maximum, a Welford running mean and a Welford sum of squared deviations. One neighbor count is shared by all lanes.

A transfer is either a data beat or an end marker. A first flag on a beat discards whatever partial record was pending and starts a new node with that beat. An end marker closes the node. Sum, minimum and maximum come out one cycle after the marker. Mean and variance need a division by the count, done by a bit-serial divider in each lane. In variance mode every data beat also needs a division for the Welford mean step. While any such division runs, the block holds its ready output low. The mode must stay the same for all transfers of one node.

Top module: `nbr_agg`

## Requirements
- R1: After reset `nb_ready` is 1 and `out_valid` is 0.
- R2: Mode 0 (sum) gives, per lane, the sum of the node's samples, saturated to the most positive or most negative W-bit value. Mode codes 5 to 7 also give the sum.
- R3: Mode 1 gives the smallest and mode 2 the largest signed sample of each lane.
- R4: Mode 3 gives the lane sum divided by the sample count, truncated toward zero.
- R5: Mode 4 gives the population variance (sum of squared deviations over n) in the same fixed-point format as the input, with FRAC fraction bits. It is within 2 LSB of the exact value, saturates at the most positive W-bit value, and is exactly 0 for a constant input.
- R6: A node that closes with no data beats gives 0 on every lane in every mode, in the cycle after the end marker is accepted.
- R7: A beat with `nb_first`=1 discards earlier partial state. So does any beat that follows a finalized node.
- R8: The data lanes of an end marker (`nb_end`=1) have no effect on the result.
- R9: After a data beat in mode 4 is accepted, `nb_ready` is 0 in the next cycle while the per-sample division runs. In modes 0 to 3 the block is ready again in the next cycle.
- R10: `out_valid` pulses for one cycle per closed node. `out_data` changes only in a cycle where `out_valid` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nb_valid | input | 1 | Transfer present |
| nb_ready | output | 1 | Transfer accepted when high together with nb_valid |
| nb_first | input | 1 | This transfer begins a new node |
| nb_end | input | 1 | End marker; data lanes ignored |
| nb_mode | input | 3 | 0 sum, 1 min, 2 max, 3 mean, 4 variance |
| nb_data | input | LANES*W | Lane i at bits [i*W +: W], signed, FRAC fraction bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | LANES*W | Result vector, lane i at bits [i*W +: W] |

## Verification
The bench goes after nodes with no neighbors. A design that finalizes from the initial min/max values or divides by a zero count would emit those values or garbage instead of zero. It drives sums past both rails, where a wrapping adder flips sign. It checks negative means, where floor division would be one lower than truncation. It feeds constant streams to the variance path, where a Welford update that drops its mean step leaves a non-zero residue. It also restarts a node mid-stream with the first flag: an accumulator that ignores the flag carries the earlier samples into the result. Finally it watches ready during variance beats, since accepting data in mid-division would corrupt the running mean.

// File: rtl/nagg_pkg.sv
package nagg_pkg;

   typedef enum logic [2:0] {
      AGG_SUM  = 3'd0,
      AGG_MIN  = 3'd1,
      AGG_MAX  = 3'd2,
      AGG_MEAN = 3'd3,
      AGG_VAR  = 3'd4
   } agg_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_UPD  = 2'd1,
      ST_FIN  = 2'd2
   } agg_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nagg_div.sv
module nagg_div #(
   parameter int NUM_W = 34,
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int ST_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [ST_W-1:0]  step_q;
   logic [DEN_W:0]   rem_sh;
   logic             ge;
   logic [DEN_W-1:0] rem_nx;

   assign rem_sh = {rem_q, quo[NUM_W-1]};
   assign ge     = rem_sh >= {1'b0, den_q};
   assign rem_nx = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         step_q <= '0;
         quo    <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_q  <= '0;
            den_q  <= den;
            quo    <= num;
            step_q <= ST_W'(NUM_W);
            busy   <= 1'b1;
         end else if (busy) begin
            rem_q  <= rem_nx;
            quo    <= {quo[NUM_W-2:0], ge};
            step_q <= step_q - ST_W'(1);
            if (step_q == ST_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R9: a new division is only launched while the divider is free
   assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/nagg_lane.sv
module nagg_lane #(
   parameter int W     = 16,
   parameter int FRAC  = 8,
   parameter int GUARD = 8,
   parameter int CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                samp_go,
   input  logic                samp_fresh,
   input  logic                wel_go,
   input  logic signed [W-1:0] samp_x,
   input  logic [CNT_W-1:0]    den_samp,
   input  logic                fin_go,
   input  logic                fin_var,
   input  logic [CNT_W-1:0]    den_fin,
   output logic                div_done,
   output logic [W-1:0]        res_sum,
   output logic [W-1:0]        res_min,
   output logic [W-1:0]        res_max,
   output logic [W-1:0]        res_mean,
   output logic [W-1:0]        res_var
);
   localparam int S_W   = W + CNT_W;
   localparam int D_W   = W + GUARD + 1;
   localparam int P_W   = 2 * D_W;
   localparam int M2_W  = P_W + CNT_W;
   localparam int SH    = 2 * GUARD + FRAC;
   localparam int V_W   = M2_W - SH;
   localparam int DIV_W = nagg_pkg::max3(D_W, S_W, V_W);

   localparam logic signed [W-1:0] X_HI = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] X_LO = {1'b1, {(W-1){1'b0}}};

   logic signed [S_W-1:0] sum_q;
   logic signed [W-1:0]   min_q, max_q;
   logic signed [D_W-1:0] mean_q, delta_q, xq_q;
   logic [M2_W-1:0]       m2_q;
   logic                  upd_q;

   logic signed [S_W-1:0] sum_base;
   logic signed [W-1:0]   min_base, max_base;
   logic signed [D_W-1:0] mean_base, xq_c, delta_c, q_s, mean_nx, diff;
   logic signed [P_W-1:0] prod;
   logic [D_W-1:0]        delta_mag;
   logic [S_W-1:0]        sum_mag;
   logic [DIV_W-1:0]      div_num, quo;
   logic [CNT_W-1:0]      div_den;
   logic                  div_busy;

   assign sum_base  = samp_fresh ? '0 : sum_q;
   assign min_base  = samp_fresh ? X_HI : min_q;
   assign max_base  = samp_fresh ? X_LO : max_q;
   assign mean_base = samp_fresh ? '0 : mean_q;

   // Welford step, scaled by 2^GUARD
   assign xq_c      = D_W'(samp_x) <<< GUARD;
   assign delta_c   = xq_c - mean_base;
   assign delta_mag = delta_c[D_W-1] ? D_W'(-delta_c) : D_W'(delta_c);
   assign q_s       = $signed(quo[D_W-1:0]);
   assign mean_nx   = delta_q[D_W-1] ? (mean_q - q_s) : (mean_q + q_s);
   assign diff      = xq_q - mean_nx;
   assign prod      = P_W'(delta_q) * P_W'(diff);

   assign sum_mag   = sum_q[S_W-1] ? S_W'(-sum_q) : S_W'(sum_q);

   always_comb begin
      if (wel_go)       div_num = DIV_W'(delta_mag);
      else if (fin_var) div_num = DIV_W'(m2_q >> SH);
      else              div_num = DIV_W'(sum_mag);
   end
   assign div_den = wel_go ? den_samp : den_fin;

   nagg_div #(.NUM_W(DIV_W), .DEN_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wel_go | fin_go),
      .num   (div_num),
      .den   (div_den),
      .busy  (div_busy),
      .done  (div_done),
      .quo   (quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q   <= '0;
         min_q   <= X_HI;
         max_q   <= X_LO;
         mean_q  <= '0;
         delta_q <= '0;
         xq_q    <= '0;
         m2_q    <= '0;
         upd_q   <= 1'b0;
      end else begin
         if (samp_go) begin
            sum_q <= sum_base + S_W'(samp_x);
            min_q <= (samp_x < min_base) ? samp_x : min_base;
            max_q <= (samp_x > max_base) ? samp_x : max_base;
         end
         if (wel_go) begin
            delta_q <= delta_c;
            xq_q    <= xq_c;
            upd_q   <= 1'b1;
            if (samp_fresh) begin
               mean_q <= '0;
               m2_q   <= '0;
            end
         end
         if (div_done && upd_q) begin
            mean_q <= mean_nx;
            m2_q   <= m2_q + M2_W'(prod);
            upd_q  <= 1'b0;
         end
      end
   end

   always_comb begin
      if (sum_q > S_W'(X_HI))      res_sum = X_HI;
      else if (sum_q < S_W'(X_LO)) res_sum = X_LO;
      else                         res_sum = sum_q[W-1:0];
   end
   assign res_min  = min_q;
   assign res_max  = max_q;
   assign res_mean = sum_q[S_W-1] ? (~quo[W-1:0] + W'(1)) : quo[W-1:0];
   assign res_var  = (|quo[DIV_W-1:W-1]) ? X_HI : quo[W-1:0];

   // R5: squared-deviation accumulator never goes negative
   assert_m2_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !m2_q[M2_W-1]);

   // R9: the Welford step completes before another sample may start one
   assert_wel_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_q && !div_done) |-> !wel_go);

endmodule

// File: rtl/nbr_agg.sv
module nbr_agg #(
   parameter int LANES = 2,
   parameter int W     = 16,
   parameter int FRAC  = 8,
   parameter int GUARD = 8,
   parameter int CNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nb_valid,
   output logic               nb_ready,
   input  logic               nb_first,
   input  logic               nb_end,
   input  logic [2:0]         nb_mode,
   input  logic [LANES*W-1:0] nb_data,
   output logic               out_valid,
   output logic [LANES*W-1:0] out_data
);
   import nagg_pkg::*;

   localparam int V_W = LANES * W;

   generate
      if (W < 4)         begin : g_bad_w    $error("W must be at least 4");            end
      if (FRAC >= W)     begin : g_bad_frac $error("FRAC must be below W");            end
      if (LANES < 1)     begin : g_bad_ln   $error("LANES must be at least 1");        end
      if (CNT_W < 2)     begin : g_bad_cnt  $error("CNT_W must be at least 2");        end
      if (GUARD < 1)     begin : g_bad_gd   $error("GUARD must be at least 1");        end
   endgenerate

   agg_state_e       state_q;
   agg_mode_e        fmode_q;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             acc, take_data, take_end, fresh, is_var, is_mean;
   logic             wel_go, fin_div, fin_now, fin_go, all_done;
   logic [LANES-1:0] lane_done;
   logic [V_W-1:0]   v_sum, v_min, v_max, v_mean, v_var;
   logic [V_W-1:0]   now_sel;

   assign nb_ready  = (state_q == ST_IDLE);
   assign acc       = nb_valid && nb_ready;
   assign take_data = acc && !nb_end;
   assign take_end  = acc && nb_end;
   assign fresh     = nb_first || (cnt_q == '0);
   assign cnt_nx    = fresh ? CNT_W'(1) : cnt_q + CNT_W'(1);
   assign is_var    = (nb_mode == AGG_VAR);
   assign is_mean   = (nb_mode == AGG_MEAN);
   assign wel_go    = take_data && is_var;
   assign fin_div   = take_end && !fresh && (is_var || is_mean);
   assign fin_now   = take_end && !fin_div;
   assign fin_go    = fin_div;
   assign all_done  = &lane_done;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         nagg_lane #(.W(W), .FRAC(FRAC), .GUARD(GUARD), .CNT_W(CNT_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .samp_go    (take_data),
            .samp_fresh (fresh),
            .wel_go     (wel_go),
            .samp_x     ($signed(nb_data[l*W +: W])),
            .den_samp   (cnt_nx),
            .fin_go     (fin_go),
            .fin_var    (is_var),
            .den_fin    (cnt_q),
            .div_done   (lane_done[l]),
            .res_sum    (v_sum[l*W +: W]),
            .res_min    (v_min[l*W +: W]),
            .res_max    (v_max[l*W +: W]),
            .res_mean   (v_mean[l*W +: W]),
            .res_var    (v_var[l*W +: W])
         );
      end
   endgenerate

   always_comb begin
      if (fresh)                   now_sel = '0;
      else if (nb_mode == AGG_MIN) now_sel = v_min;
      else if (nb_mode == AGG_MAX) now_sel = v_max;
      else                         now_sel = v_sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         fmode_q   <= AGG_SUM;
         cnt_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (wel_go)  state_q <= ST_UPD;
               if (fin_div) state_q <= ST_FIN;
            end
            ST_UPD:  if (all_done) state_q <= ST_IDLE;
            ST_FIN:  if (all_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
         if (take_data) cnt_q <= cnt_nx;
         if (take_end)  fmode_q <= agg_mode_e'(nb_mode);
         if (fin_now) begin
            cnt_q     <= '0;
            out_valid <= 1'b1;
            out_data  <= now_sel;
         end
         if (state_q == ST_FIN && all_done) begin
            cnt_q     <= '0;
            out_valid <= 1'b1;
            out_data  <= (fmode_q == AGG_VAR) ? v_var : v_mean;
         end
      end
   end

   // R9: a variance beat blocks the next transfer while it divides
   assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_valid && nb_ready && !nb_end && nb_mode == AGG_VAR) |=> !nb_ready);

   // R6: an empty node closes to all zeros one cycle later
   assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_valid && nb_ready && nb_end && nb_first) |=> (out_valid && out_data == '0));

   // R10: the result register only moves together with the strobe
   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

endmodule

// File: tb/nbr_agg_tb.sv
module nbr_agg_tb;
   localparam int LANES = 2;
   localparam int W     = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               nb_valid = 1'b0;
   logic               nb_ready;
   logic               nb_first = 1'b0;
   logic               nb_end = 1'b0;
   logic [2:0]         nb_mode = 3'd0;
   logic [LANES*W-1:0] nb_data = '0;
   logic               out_valid;
   logic [LANES*W-1:0] out_data;

   int checks = 0;
   int fails  = 0;
   int xs [LANES][16];
   int got [LANES];
   bit ready_after;

   always #2.5 clk = ~clk;

   nbr_agg u_dut (
      .clk(clk), .rst_n(rst_n), .nb_valid(nb_valid), .nb_ready(nb_ready),
      .nb_first(nb_first), .nb_end(nb_end), .nb_mode(nb_mode), .nb_data(nb_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic xfer(input bit first, input bit endf, input logic [2:0] md,
                       input logic [LANES*W-1:0] data);
      @(negedge clk);
      nb_valid = 1'b1; nb_first = first; nb_end = endf; nb_mode = md; nb_data = data;
      while (!nb_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      nb_valid = 1'b0; nb_first = 1'b0; nb_end = 1'b0;
      ready_after = nb_ready;
   endtask

   // called at the negedge right after an end marker was accepted
   task automatic wait_result();
      logic [LANES*W-1:0] held;
      while (!out_valid) @(negedge clk);
      for (int l = 0; l < LANES; l++) got[l] = int'($signed(out_data[l*W +: W]));
      held = out_data;
      @(negedge clk);
      chk(!out_valid, "R10 pulse", int'(out_valid), 0);
      chk(out_data == held, "R10 hold", int'(out_data[W-1:0]), int'(held[W-1:0]));
   endtask

   function automatic int exp_val(input int md, input int l, input int n);
      int s, m;
      if (n == 0) return 0;
      s = 0;
      for (int i = 0; i < n; i++) s += xs[l][i];
      case (md)
         1: begin m = xs[l][0]; for (int i = 1; i < n; i++) if (xs[l][i] < m) m = xs[l][i]; return m; end
         2: begin m = xs[l][0]; for (int i = 1; i < n; i++) if (xs[l][i] > m) m = xs[l][i]; return m; end
         3: return s / n;
         4: begin
            real mu, v;
            mu = real'(s) / n;
            v = 0.0;
            for (int i = 0; i < n; i++) v += (xs[l][i] - mu) * (xs[l][i] - mu);
            v = v / n / 256.0;
            m = int'($floor(v));
            return (m > 32767) ? 32767 : m;
         end
         default: return (s > 32767) ? 32767 : ((s < -32768) ? -32768 : s);
      endcase
   endfunction

   function automatic string req_of(input int md, input int n);
      if (n == 0) return "R6 empty";
      case (md)
         1, 2: return "R3 min/max";
         3: return "R4 mean";
         4: return "R5 variance";
         default: return "R2 sum";
      endcase
   endfunction

   task automatic run_node(input int md, input int n, input logic [LANES*W-1:0] junk);
      logic [LANES*W-1:0] d;
      int e, dif;
      if (n == 0) xfer(1'b1, 1'b1, 3'(md), junk);
      else begin
         for (int i = 0; i < n; i++) begin
            for (int l = 0; l < LANES; l++) d[l*W +: W] = 16'(xs[l][i]);
            xfer(i == 0, 1'b0, 3'(md), d);
            if (md == 4) chk(ready_after == 1'b0, "R9 busy", int'(ready_after), 0);
            else         chk(ready_after == 1'b1, "R9 free", int'(ready_after), 1);
         end
         xfer(1'b0, 1'b1, 3'(md), junk);
      end
      wait_result();
      for (int l = 0; l < LANES; l++) begin
         e = exp_val(md, l, n);
         if (md == 4 && n > 0) begin
            dif = got[l] - e;
            chk(dif <= 2 && dif >= -2, req_of(md, n), got[l], e);
         end else chk(got[l] == e, req_of(md, n), got[l], e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] r;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(nb_ready == 1'b1, "R1 ready", int'(nb_ready), 1);
      chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);

      // R6: empty nodes in every mode, end marker carries junk
      for (int md = 0; md < 5; md++) run_node(md, 0, 32'hDEAD_BEEF);

      // R2: saturation at both rails
      for (int i = 0; i < 4; i++) begin xs[0][i] = 30000; xs[1][i] = -30000; end
      run_node(0, 4, 32'h0);
      // R2: mode codes above 4 act as sum
      xs[0][0] = 5; xs[1][0] = -9; xs[0][1] = 7; xs[1][1] = 2;
      run_node(6, 2, 32'h0);

      // R3
      xs[0][0] = -5; xs[0][1] = 300; xs[0][2] = -32768;
      xs[1][0] = 32767; xs[1][1] = 0; xs[1][2] = -1;
      run_node(1, 3, 32'h0);
      run_node(2, 3, 32'h0);

      // R4: negative mean truncates toward zero
      xs[0][0] = -3; xs[0][1] = -4; xs[1][0] = 3; xs[1][1] = 4;
      run_node(3, 2, 32'h0);

      // R5: constant input gives exactly zero, two-point spread
      for (int i = 0; i < 5; i++) begin xs[0][i] = 1000; xs[1][i] = -777; end
      run_node(4, 5, 32'h0);
      chk(got[0] == 0, "R5 constant", got[0], 0);
      chk(got[1] == 0, "R5 constant", got[1], 0);
      xs[0][0] = 0; xs[0][1] = 512; xs[1][0] = -2000; xs[1][1] = 2000;
      run_node(4, 2, 32'h0);

      // R7: first flag mid-node drops earlier beats
      xfer(1'b1, 1'b0, 3'd0, {16'd100, 16'd100});
      xfer(1'b0, 1'b0, 3'd0, {16'd100, 16'd100});
      xfer(1'b1, 1'b0, 3'd0, {16'd3, 16'd7});
      xfer(1'b0, 1'b1, 3'd0, 32'h0);
      wait_result();
      chk(got[0] == 7, "R7 restart", got[0], 7);
      chk(got[1] == 3, "R7 restart", got[1], 3);
      // R7: a beat after a closed node starts fresh without the flag
      xfer(1'b0, 1'b0, 3'd1, {16'd50, 16'd60});
      xfer(1'b0, 1'b1, 3'd1, 32'h0);
      wait_result();
      chk(got[0] == 60, "R7 after close", got[0], 60);
      chk(got[1] == 50, "R7 after close", got[1], 50);

      // R8: end marker data ignored
      xfer(1'b1, 1'b0, 3'd2, {16'd10, 16'hFFF0});
      xfer(1'b0, 1'b1, 3'd2, {16'h7FFF, 16'h7FFF});
      wait_result();
      chk(got[0] == -16, "R8 end data", got[0], -16);
      chk(got[1] == 10, "R8 end data", got[1], 10);

      // random nodes
      for (int k = 0; k < 150; k++) begin
         int md, n;
         md = int'($urandom_range(0, 4));
         n  = int'($urandom_range(0, 8));
         for (int i = 0; i < n; i++)
            for (int l = 0; l < LANES; l++) begin
               if (md == 4) xs[l][i] = int'($urandom_range(0, 4000)) - 2000;
               else begin r = 16'($urandom); xs[l][i] = int'($signed(r)); end
            end
         run_node(md, n, 32'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule